// File: doc/BRIEF.md
# Flash Status Register Protection Unit

This block keeps the eight-bit software status register of a serial NOR flash and applies the rules that guard it. The command decoder gives it one-cycle strobes for the commands it has already recognised. The program and erase engines give it completion strobes and a busy level. The unit returns the status byte that a status read shifts out, the write-enable latch, and two gating flags. One flag says whether the address now targeted lies in a protected region. The other says whether a full-array erase may start.

Writing the status register takes two steps. An arming command must come first, and the status write must be the very next command. Any other command in between cancels the arming. A lock bit in the register works with the active-low write-protect pin. When the pin is low and the lock bit is set, the register cannot be changed. When the pin is high, the lock bit has no effect. A two-bit protection field selects one of four regions at the top of the array: none, the top quarter, the top half, or all of it.

Top module: `flash_sr_guard`

## Requirements
- R1: The status byte carries busy at bit 0 (a copy of `busy_i`), the write-enable latch at bit 1, protection bits P0 and P1 at bits 2 and 3, zeros at bits 5:4, auto-increment mode at bit 6 and the lock bit at bit 7.
- R2: After reset the status byte reads 8'h0C while `busy_i` is low: P1:P0 = 11, and lock, latch and auto-increment are all 0.
- R3: A status write strobe updates bits 7, 3 and 2 from the same bits of `sr_data_i`, but only when the previous command strobe was the arming strobe. A status write with no arming first, or with any other command strobe after the arming strobe, leaves the register unchanged.
- R4: A status write is refused when `wp_ni` is low and the lock bit is 1. With `wp_ni` high, a locked register can be rewritten, including clearing the lock. With `wp_ni` low and the lock at 0, one write can set the lock and change P1:P0 together.
- R5: `addr_prot_o` is high when P1:P0 = 11 for any address. It is high when P1:P0 = 10 for addresses with bit 16 set (10000h–1FFFFh). It is high when P1:P0 = 01 for addresses with bits 16:15 both set (18000h–1FFFFh). It is never high when P1:P0 = 00.
- R6: `chip_erase_ok_o` is high exactly when P1:P0 = 00.
- R7: The write-enable strobe sets the latch. The write-disable strobe clears both the latch and the auto-increment bit.
- R8: Completion of a byte program, sector erase, block erase or chip erase clears the latch. Reaching the top address in auto-increment programming clears both the latch and the auto-increment bit. A clearing event wins over a write-enable strobe in the same cycle.
- R9: The auto-increment start strobe sets the auto-increment bit.
- R10: A status write never changes busy, the latch or the auto-increment bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wren_i | input | 1 | Write-enable command strobe |
| wrdi_i | input | 1 | Write-disable command strobe |
| sr_arm_i | input | 1 | Strobe for the command that arms a status write |
| sr_write_i | input | 1 | Status-write command strobe |
| sr_data_i | input | 8 | Data byte of the status write |
| other_cmd_i | input | 1 | Strobe for any other decoded command |
| prog_done_i | input | 1 | Byte program finished |
| sect_done_i | input | 1 | Sector erase finished |
| blk_done_i | input | 1 | Block erase finished |
| chip_done_i | input | 1 | Chip erase finished |
| aai_start_i | input | 1 | Auto-increment programming entered |
| aai_top_i | input | 1 | Auto-increment programming reached the top address |
| busy_i | input | 1 | An internal program or erase is in progress |
| wp_ni | input | 1 | Write-protect pin, active low |
| addr_i | input | 17 | Address targeted by the pending program or erase |
| status_o | output | 8 | Status byte |
| wel_o | output | 1 | Write-enable latch |
| addr_prot_o | output | 1 | Target address is protected |
| chip_erase_ok_o | output | 1 | Full-array erase is allowed |

## Verification
On every cycle, the assertions check four things. A status write that was not armed, or that the pin and lock refuse, leaves the protection bits unchanged. A write-enable strobe with no clearing event leaves the latch set. Each completion strobe leaves the latch clear. The two gating outputs agree with the protection field. Only the bench scenarios show the rest. These include the exact bits a write copies, that one stray command between arming and write cancels the arming, the reset value, and the address boundaries of every protection level. They also include the lock being set and later released as the pin changes.

// File: rtl/flash_sr_pkg.sv
package flash_sr_pkg;
  localparam int SR_W     = 8;
  localparam int BIT_BUSY = 0;
  localparam int BIT_WEL  = 1;
  localparam int BIT_P0   = 2;
  localparam int BIT_P1   = 3;
  localparam int BIT_AAI  = 6;
  localparam int BIT_LOCK = 7;

  typedef enum logic [1:0] {
    PROT_NONE    = 2'b00,
    PROT_QUARTER = 2'b01,
    PROT_HALF    = 2'b10,
    PROT_ALL     = 2'b11
  } prot_lvl_e;

  localparam prot_lvl_e PROT_RESET = PROT_ALL;
endpackage

// File: rtl/sr_arm_tracker.sv
module sr_arm_tracker (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic any_cmd_i,
  output logic armed_o
);
  logic armed_q;

  // armed only across the single next command
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        armed_q <= 1'b0;
    else if (arm_i)     armed_q <= 1'b1;
    else if (any_cmd_i) armed_q <= 1'b0;
  end

  assign armed_o = armed_q;

  // R3
  arm_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_cmd_i && !arm_i) |=> !armed_q);
endmodule

// File: rtl/sr_lock_regs.sv
module sr_lock_regs
  import flash_sr_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            write_i,
  input  logic            armed_i,
  input  logic            wp_ni,
  input  logic [SR_W-1:0] data_i,
  output prot_lvl_e       prot_o,
  output logic            lock_o
);
  prot_lvl_e prot_q;
  logic      lock_q;
  logic      accept;

  assign accept = write_i && armed_i && !(!wp_ni && lock_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prot_q <= PROT_RESET;
      lock_q <= 1'b0;
    end else if (accept) begin
      prot_q <= prot_lvl_e'({data_i[BIT_P1], data_i[BIT_P0]});
      lock_q <= data_i[BIT_LOCK];
    end
  end

  assign prot_o = prot_q;
  assign lock_o = lock_q;

  // R3
  unarmed_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (write_i && !armed_i) |=> $stable({lock_q, prot_q}));
  // R4
  locked_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (write_i && !wp_ni && lock_q) |=> $stable({lock_q, prot_q}));
endmodule

// File: rtl/sr_wel_ctrl.sv
module sr_wel_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wren_i,
  input  logic wrdi_i,
  input  logic op_done_i,
  input  logic aai_start_i,
  input  logic aai_top_i,
  output logic wel_o,
  output logic aai_o
);
  logic wel_q, aai_q, wel_clr, aai_clr;

  assign wel_clr = wrdi_i || op_done_i || aai_top_i;
  assign aai_clr = wrdi_i || aai_top_i;

  // clearing wins over a coincident set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q <= 1'b0;
      aai_q <= 1'b0;
    end else begin
      if (wel_clr)          wel_q <= 1'b0;
      else if (wren_i)      wel_q <= 1'b1;
      if (aai_clr)          aai_q <= 1'b0;
      else if (aai_start_i) aai_q <= 1'b1;
    end
  end

  assign wel_o = wel_q;
  assign aai_o = aai_q;

  // R7
  wel_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wren_i && !wrdi_i && !op_done_i && !aai_top_i) |=> wel_q);
  // R8
  wel_done_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_done_i || aai_top_i) |=> !wel_q);
  // R8
  aai_top_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aai_top_i |=> !aai_q);
endmodule

// File: rtl/sr_range_check.sv
module sr_range_check
  import flash_sr_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  prot_lvl_e         prot_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              prot_o,
  output logic              chip_ok_o
);
  localparam int TOP = ADDR_W - 1;

  logic in_half, in_quarter;

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign in_half    = addr_i[TOP];
      assign in_quarter = addr_i[TOP] && addr_i[TOP-1];
    end else begin : g_narrow
      assign in_half    = addr_i[0];
      assign in_quarter = addr_i[0];
    end
  endgenerate

  always_comb begin
    unique case (prot_i)
      PROT_NONE:    prot_o = 1'b0;
      PROT_QUARTER: prot_o = in_quarter;
      PROT_HALF:    prot_o = in_half;
      default:      prot_o = 1'b1;
    endcase
  end

  assign chip_ok_o = (prot_i == PROT_NONE);
endmodule

// File: rtl/flash_sr_guard.sv
module flash_sr_guard
  import flash_sr_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              sr_arm_i,
  input  logic              sr_write_i,
  input  logic [SR_W-1:0]   sr_data_i,
  input  logic              other_cmd_i,
  input  logic              prog_done_i,
  input  logic              sect_done_i,
  input  logic              blk_done_i,
  input  logic              chip_done_i,
  input  logic              aai_start_i,
  input  logic              aai_top_i,
  input  logic              busy_i,
  input  logic              wp_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [SR_W-1:0]   status_o,
  output logic              wel_o,
  output logic              addr_prot_o,
  output logic              chip_erase_ok_o
);
  logic      any_cmd, armed, lock, wel, aai, op_done;
  prot_lvl_e prot;

  assign any_cmd = wren_i || wrdi_i || sr_arm_i || sr_write_i || other_cmd_i;
  assign op_done = prog_done_i || sect_done_i || blk_done_i || chip_done_i;

  sr_arm_tracker u_arm (
    .clk_i, .rst_ni,
    .arm_i     (sr_arm_i),
    .any_cmd_i (any_cmd),
    .armed_o   (armed)
  );

  sr_lock_regs u_lock (
    .clk_i, .rst_ni,
    .write_i (sr_write_i),
    .armed_i (armed),
    .wp_ni,
    .data_i  (sr_data_i),
    .prot_o  (prot),
    .lock_o  (lock)
  );

  sr_wel_ctrl u_wel (
    .clk_i, .rst_ni,
    .wren_i, .wrdi_i,
    .op_done_i   (op_done),
    .aai_start_i, .aai_top_i,
    .wel_o       (wel),
    .aai_o       (aai)
  );

  sr_range_check #(.ADDR_W(ADDR_W)) u_range (
    .prot_i    (prot),
    .addr_i,
    .prot_o    (addr_prot_o),
    .chip_ok_o (chip_erase_ok_o)
  );

  always_comb begin
    status_o           = '0;
    status_o[BIT_BUSY] = busy_i;
    status_o[BIT_WEL]  = wel;
    status_o[BIT_P0]   = prot[0];
    status_o[BIT_P1]   = prot[1];
    status_o[BIT_AAI]  = aai;
    status_o[BIT_LOCK] = lock;
  end

  assign wel_o = wel;

  // R5
  full_prot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[BIT_P1] && status_o[BIT_P0]) |-> addr_prot_o);
  // R6
  chip_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_erase_ok_o |-> (status_o[BIT_P1:BIT_P0] == 2'b00 && !addr_prot_o));
  // R10
  sr_write_keeps_wel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_write_i && !wren_i && !wrdi_i && !op_done && !aai_top_i) |=> $stable(wel));
endmodule

// File: tb/flash_sr_guard_bench.sv
module flash_sr_guard_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wren, wrdi, arm, srw, other;
  logic [7:0]  data;
  logic        pdone, sdone, bdone, cdone, astart, atop, busy, wp_n;
  logic [16:0] addr;
  logic [7:0]  status;
  logic        wel, prot, chip_ok;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  flash_sr_guard u_flash_sr_guard (
    .clk_i(clk), .rst_ni(rst_ni),
    .wren_i(wren), .wrdi_i(wrdi), .sr_arm_i(arm), .sr_write_i(srw),
    .sr_data_i(data), .other_cmd_i(other),
    .prog_done_i(pdone), .sect_done_i(sdone), .blk_done_i(bdone), .chip_done_i(cdone),
    .aai_start_i(astart), .aai_top_i(atop), .busy_i(busy), .wp_ni(wp_n),
    .addr_i(addr), .status_o(status), .wel_o(wel),
    .addr_prot_o(prot), .chip_erase_ok_o(chip_ok)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    wren = 0; wrdi = 0; arm = 0; srw = 0; other = 0; data = 8'h00;
    pdone = 0; sdone = 0; bdone = 0; cdone = 0; astart = 0; atop = 0;
  endtask

  // one-cycle pulse; returns at the next falling edge, after the update
  task automatic pulse(input string which, input logic [7:0] d);
    @(negedge clk);
    case (which)
      "wren":  wren = 1;
      "wrdi":  wrdi = 1;
      "arm":   arm = 1;
      "srw":   begin srw = 1; data = d; end
      "other": other = 1;
      "pdone": pdone = 1;
      "sdone": sdone = 1;
      "bdone": bdone = 1;
      "cdone": cdone = 1;
      "astart": astart = 1;
      "atop":  atop = 1;
      default: ;
    endcase
    @(negedge clk);
    idle();
  endtask

  task automatic sr_write(input logic [7:0] d);
    pulse("arm", 8'h00);
    pulse("srw", d);
  endtask

  task automatic t_reset();
    chk("R2 reset status", status, 8'h0C);
    chk("R2 reset wel", wel, 0);
    busy = 1; #1;
    chk("R1 busy bit", status, 8'h0D);
    busy = 0; #1;
  endtask

  task automatic t_wel();
    pulse("wren", 0);
    chk("R7 wren sets", status, 8'h0E);
    pulse("astart", 0);
    chk("R9 aai set", status, 8'h4E);
    pulse("wrdi", 0);
    chk("R7 wrdi clears wel and aai", status, 8'h0C);
  endtask

  task automatic t_done();
    pulse("wren", 0); pulse("pdone", 0); chk("R8 prog done", wel, 0);
    pulse("wren", 0); pulse("sdone", 0); chk("R8 sector done", wel, 0);
    pulse("wren", 0); pulse("bdone", 0); chk("R8 block done", wel, 0);
    pulse("wren", 0); pulse("cdone", 0); chk("R8 chip done", wel, 0);
    pulse("wren", 0); pulse("astart", 0);
    pulse("atop", 0);
    chk("R8 aai top clears wel and aai", status, 8'h0C);
    @(negedge clk); wren = 1; pdone = 1; @(negedge clk); idle();
    chk("R8 clear beats wren", wel, 0);
  endtask

  task automatic t_arming();
    pulse("srw", 8'h00);
    chk("R3 unarmed write ignored", status, 8'h0C);
    pulse("arm", 0); pulse("other", 0); pulse("srw", 8'h00);
    chk("R3 intervening command cancels", status, 8'h0C);
    pulse("arm", 0); pulse("wren", 0); pulse("srw", 8'h00);
    chk("R3 wren cancels arming", status, 8'h0E);
    sr_write(8'hFB);
    chk("R3 R10 armed write bits 7,3,2 only", status, 8'h8A);
    pulse("arm", 0); pulse("arm", 0); pulse("srw", 8'h04);
    chk("R3 repeated arm still arms", status, 8'h06);
    pulse("srw", 8'h00);
    chk("R3 arming spent after write", status, 8'h06);
    pulse("wrdi", 0);
  endtask

  task automatic t_ranges();
    sr_write(8'h00);
    addr = 17'h1FFFF; #1;
    chk("R5 none top", prot, 0);
    chk("R6 chip ok none", chip_ok, 1);
    sr_write(8'h04);
    addr = 17'h17FFF; #1; chk("R5 quarter below", prot, 0);
    addr = 17'h18000; #1; chk("R5 quarter edge", prot, 1);
    chk("R6 chip blocked quarter", chip_ok, 0);
    sr_write(8'h08);
    addr = 17'h0FFFF; #1; chk("R5 half below", prot, 0);
    addr = 17'h10000; #1; chk("R5 half edge", prot, 1);
    chk("R6 chip blocked half", chip_ok, 0);
    sr_write(8'h0C);
    addr = 17'h00000; #1; chk("R5 all bottom", prot, 1);
    chk("R6 chip blocked all", chip_ok, 0);
  endtask

  task automatic t_lock();
    wp_n = 0;
    sr_write(8'h80);
    chk("R4 wp low lock 0 sets lock", status, 8'h80);
    sr_write(8'h0C);
    chk("R4 wp low locked refused", status, 8'h80);
    wp_n = 1;
    sr_write(8'h08);
    chk("R4 wp high clears lock", status, 8'h08);
    sr_write(8'h84);
    wp_n = 0;
    sr_write(8'h00);
    chk("R4 relocked refused", status, 8'h84);
    wp_n = 1;
    sr_write(8'h0C);
    chk("R4 wp high lock ignored", status, 8'h0C);
  endtask

  initial begin
    idle(); busy = 0; wp_n = 1; addr = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_wel();
    t_done();
    t_arming();
    t_ranges();
    t_lock();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule